// File: doc/BRIEF.md
# Load-Linked Reservation Monitor

This block keeps the atomic reservation for one processor's load-linked / store-conditional sequences. It watches the core's memory request stream, the exception-return pulse, and snoop notices from other bus masters. It holds a single link bit and the line address that the last load-linked touched. When a store-conditional is presented, the block answers in the same cycle with a success flag and a matching write enable. The memory write may only go ahead when both are high.

Requests carry line addresses: the caller drops the byte offset before it presents an address. The monitor has no cache-attribute input. A load-linked to uncached memory therefore sets the link exactly as a cached one does, and an exception return clears it whatever the attribute of the reserved line. The link and the reserved line are brought out as outputs so that the surrounding pipeline can observe them.

Top module: `resv_mon`

## Requirements
- R1: A synchronous active-high reset clears the link: `resv_active` is 0 in the cycle after any cycle with `rst` high.
- R2: A valid request with `req_op` = 2'b10 (load-linked) sets `resv_active` in the next cycle and records `req_line` in `resv_line`.
- R3: A valid request with `req_op` = 2'b11 (store-conditional) drives `sc_ok` and `sc_wr_en` high in the same cycle only if `resv_active` is 1 and `req_line` equals `resv_line`; otherwise both are 0.
- R4: A store-conditional clears the link in the next cycle, whether it succeeds or fails.
- R5: A cycle with `xret` high clears the link in the next cycle unless a load-linked is presented in that cycle.
- R6: A cycle with `snoop_valid` high and `snoop_line` equal to `resv_line` clears the link. A snoop to any other line leaves the link and the line unchanged.
- R7: A plain store (`req_op` = 2'b01) to the reserved line clears the link. A store to another line, or a plain load (`req_op` = 2'b00) to any line, leaves the link unchanged.
- R8: When a load-linked and any clear event fall in the same cycle, the load-linked wins: the link is set and the new line is recorded.
- R9: `sc_ok` and `sc_wr_en` are 0 in every cycle without a valid store-conditional, including cycles where `req_valid` is low and `req_op` reads 2'b11.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Core memory request present |
| req_op | input | 2 | 00 load, 01 store, 10 load-linked, 11 store-conditional |
| req_line | input | LINE_W | Line address of the request |
| xret | input | 1 | Exception-return pulse |
| snoop_valid | input | 1 | Intervention or snoop from another master |
| snoop_line | input | LINE_W | Line address of the snoop |
| sc_ok | output | 1 | Store-conditional succeeded (same cycle) |
| sc_wr_en | output | 1 | Permission for the store-conditional's memory write |
| resv_active | output | 1 | Link bit |
| resv_line | output | LINE_W | Reserved line address |

## Verification
The case that needs the most care is a load-linked that lands in the same cycle as a clear event. The clear event may be an exception return, a snoop hit on the old line, or a snoop on the new line. The bench drives each of these pairs in a single cycle and expects the link to be set, with the newly requested line recorded. A store-conditional that meets an exception return in the same cycle is also driven. It must be judged against the link as it stood before that edge, so it succeeds, and the link drops afterwards. A behavioural model in the bench predicts every output each cycle.

// File: rtl/resv_pkg.sv
package resv_pkg;

    typedef enum logic [1:0] {
        OP_LOAD  = 2'b00,
        OP_STORE = 2'b01,
        OP_LL    = 2'b10,
        OP_SC    = 2'b11
    } resv_op_e;

    // Decoded per-cycle events feeding the link register.
    typedef struct packed {
        logic set;   // load-linked seen
        logic clr;   // any event that drops the link
    } resv_evt_t;

endpackage

// File: rtl/resv_req_decode.sv
module resv_req_decode
    import resv_pkg::*;
#(
    parameter int LINE_W = 28
) (
    input  logic              req_valid,
    input  resv_op_e          req_op,
    input  logic [LINE_W-1:0] req_line,
    input  logic              xret,
    input  logic              snoop_valid,
    input  logic [LINE_W-1:0] snoop_line,
    input  logic              link_q,
    input  logic [LINE_W-1:0] line_q,
    output resv_evt_t         evt,
    output logic              sc_pass
);
    logic req_hit;
    logic snoop_hit;
    logic is_sc;
    logic is_st;

    always_comb begin
        req_hit   = (req_line == line_q);
        snoop_hit = snoop_valid && (snoop_line == line_q);
        is_sc     = req_valid && (req_op == OP_SC);
        is_st     = req_valid && (req_op == OP_STORE);
        evt.set   = req_valid && (req_op == OP_LL);
        evt.clr   = xret || snoop_hit || (is_st && req_hit) || is_sc;
        sc_pass   = is_sc && link_q && req_hit;
    end
endmodule

// File: rtl/resv_link_reg.sv
module resv_link_reg
    import resv_pkg::*;
#(
    parameter int LINE_W = 28
) (
    input  logic              clk,
    input  logic              rst,
    input  resv_evt_t         evt,
    input  logic [LINE_W-1:0] new_line,
    output logic              link_q,
    output logic [LINE_W-1:0] line_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            link_q <= 1'b0;
            line_q <= '0;
        end else if (evt.set) begin
            link_q <= 1'b1;
            line_q <= new_line;
        end else if (evt.clr) begin
            link_q <= 1'b0;
        end
    end
endmodule

// File: rtl/resv_mon.sv
module resv_mon
    import resv_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 16,
    localparam int OFS_W     = $clog2(LINE_BYTES),
    localparam int LINE_W    = ADDR_W - OFS_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [1:0]        req_op,
    input  logic [LINE_W-1:0] req_line,
    input  logic              xret,
    input  logic              snoop_valid,
    input  logic [LINE_W-1:0] snoop_line,
    output logic              sc_ok,
    output logic              sc_wr_en,
    output logic              resv_active,
    output logic [LINE_W-1:0] resv_line
);
    resv_evt_t evt;
    logic      sc_pass;
    resv_op_e  op;

    assign op = resv_op_e'(req_op);

    resv_req_decode #(.LINE_W(LINE_W)) dec_i (
        .req_valid  (req_valid),
        .req_op     (op),
        .req_line   (req_line),
        .xret       (xret),
        .snoop_valid(snoop_valid),
        .snoop_line (snoop_line),
        .link_q     (resv_active),
        .line_q     (resv_line),
        .evt        (evt),
        .sc_pass    (sc_pass)
    );

    resv_link_reg #(.LINE_W(LINE_W)) reg_i (
        .clk     (clk),
        .rst     (rst),
        .evt     (evt),
        .new_line(req_line),
        .link_q  (resv_active),
        .line_q  (resv_line)
    );

    assign sc_ok    = sc_pass;
    assign sc_wr_en = sc_pass;
endmodule

// File: rtl/resv_mon_chk.sv
module resv_mon_chk #(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 16,
    localparam int OFS_W     = $clog2(LINE_BYTES),
    localparam int LINE_W    = ADDR_W - OFS_W
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic [1:0]        req_op,
    input logic [LINE_W-1:0] req_line,
    input logic              xret,
    input logic              snoop_valid,
    input logic [LINE_W-1:0] snoop_line,
    input logic              sc_ok,
    input logic              sc_wr_en,
    input logic              resv_active,
    input logic [LINE_W-1:0] resv_line
);
    logic ll_now;
    assign ll_now = req_valid && (req_op == 2'b10);

    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> !resv_active);

    p_ll_sets_r2: assert property (@(posedge clk) disable iff (rst)
        ll_now |=> (resv_active && resv_line == $past(req_line)));

    p_sc_needs_link_r3: assert property (@(posedge clk) disable iff (rst)
        sc_ok |-> (resv_active && req_line == resv_line));

    p_sc_drops_link_r4: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_op == 2'b11) |=> !resv_active);

    p_xret_drops_r5: assert property (@(posedge clk) disable iff (rst)
        (xret && !ll_now) |=> !resv_active);

    p_snoop_hit_r6: assert property (@(posedge clk) disable iff (rst)
        (snoop_valid && snoop_line == resv_line && !ll_now) |=> !resv_active);

    p_ll_wins_r8: assert property (@(posedge clk) disable iff (rst)
        (ll_now && (xret || snoop_valid)) |=> resv_active);

    p_sc_only_r9: assert property (@(posedge clk) disable iff (rst)
        (sc_ok || sc_wr_en) |-> (req_valid && req_op == 2'b11));
endmodule

bind resv_mon resv_mon_chk #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES)) chk_i (.*);

// File: tb/resv_mon_tb_top.sv
module resv_mon_tb_top;
    localparam int LW = 28;

    logic          clk = 1'b0;
    logic          rst;
    logic          req_valid;
    logic [1:0]    req_op;
    logic [LW-1:0] req_line;
    logic          xret;
    logic          snoop_valid;
    logic [LW-1:0] snoop_line;
    logic          sc_ok, sc_wr_en, resv_active;
    logic [LW-1:0] resv_line;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 0;

    // Behavioural reference state
    bit            m_link = 0;
    logic [LW-1:0] m_line = '0;

    always #5 clk = ~clk;

    resv_mon dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
        .req_line(req_line), .xret(xret), .snoop_valid(snoop_valid),
        .snoop_line(snoop_line), .sc_ok(sc_ok), .sc_wr_en(sc_wr_en),
        .resv_active(resv_active), .resv_line(resv_line)
    );

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // One clock: apply inputs, compare outputs against the model, advance the model.
    task automatic cyc(input string req, input bit r, input bit v, input logic [1:0] op,
                       input logic [LW-1:0] ln, input bit x, input bit sv, input logic [LW-1:0] sl);
        bit exp_ok;
        @(negedge clk);
        rst = r; req_valid = v; req_op = op; req_line = ln;
        xret = x; snoop_valid = sv; snoop_line = sl;
        #1;
        exp_ok = v && op == 2'b11 && m_link && ln == m_line;
        chk(req, "sc_ok", 64'(sc_ok), 64'(exp_ok));
        chk(req, "sc_wr_en", 64'(sc_wr_en), 64'(exp_ok));
        chk(req, "resv_active", 64'(resv_active), 64'(m_link));
        if (m_link) chk(req, "resv_line", 64'(resv_line), 64'(m_line));
        if (r) m_link = 0;
        else if (v && op == 2'b10) begin m_link = 1; m_line = ln; end
        else if (x || (sv && sl == m_line) || (v && op == 2'b11) ||
                 (v && op == 2'b01 && ln == m_line)) m_link = 0;
    endtask

    task automatic idle(input string req);
        cyc(req, 0, 0, 2'b00, '0, 0, 0, '0);
    endtask

    localparam logic [LW-1:0] A = 28'h0000A10;
    localparam logic [LW-1:0] B = 28'h0000B20;

    initial begin
        cyc("R1", 1, 0, 2'b00, '0, 0, 0, '0);
        cyc("R1", 1, 0, 2'b00, '0, 0, 0, '0);
        idle("R1");
        // R2 set, R7 load keeps, R3 success, R4 cleared
        cyc("R2", 0, 1, 2'b10, A, 0, 0, '0);
        cyc("R7", 0, 1, 2'b00, A, 0, 0, '0);
        cyc("R3", 0, 1, 2'b11, A, 0, 0, '0);
        cyc("R4", 0, 1, 2'b11, A, 0, 0, '0);
        idle("R4");
        // SC to other line fails and clears
        cyc("R2", 0, 1, 2'b10, A, 0, 0, '0);
        cyc("R3", 0, 1, 2'b11, B, 0, 0, '0);
        cyc("R4", 0, 1, 2'b11, A, 0, 0, '0);
        // stores
        cyc("R2", 0, 1, 2'b10, A, 0, 0, '0);
        cyc("R7", 0, 1, 2'b01, B, 0, 0, '0);
        cyc("R7", 0, 1, 2'b01, A, 0, 0, '0);
        idle("R7");
        // snoops
        cyc("R2", 0, 1, 2'b10, A, 0, 0, '0);
        cyc("R6", 0, 0, 2'b00, '0, 0, 1, B);
        cyc("R6", 0, 0, 2'b00, '0, 0, 1, A);
        idle("R6");
        // exception return
        cyc("R2", 0, 1, 2'b10, B, 0, 0, '0);
        cyc("R5", 0, 0, 2'b00, '0, 1, 0, '0);
        cyc("R5", 0, 0, 2'b00, '0, 1, 0, '0);
        idle("R5");
        // load-linked wins over same-cycle clears
        cyc("R8", 0, 1, 2'b10, A, 0, 1, A);
        cyc("R8", 0, 1, 2'b10, B, 1, 1, A);
        cyc("R8", 0, 1, 2'b10, A, 1, 1, B);
        idle("R8");
        // SC with xret in the same cycle: judged on the prior link
        cyc("R5", 0, 1, 2'b11, A, 1, 0, '0);
        idle("R4");
        // R9: SC opcode without valid does nothing
        cyc("R2", 0, 1, 2'b10, A, 0, 0, '0);
        cyc("R9", 0, 0, 2'b11, A, 0, 0, '0);
        cyc("R9", 0, 1, 2'b00, A, 0, 0, '0);
        cyc("R3", 0, 1, 2'b11, A, 0, 0, '0);
        // reset while linked
        cyc("R2", 0, 1, 2'b10, B, 0, 0, '0);
        cyc("R1", 1, 0, 2'b00, '0, 0, 0, '0);
        idle("R1");
        cyc("R3", 0, 1, 2'b11, B, 0, 0, '0);
        idle("R3");
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule